// File: doc/BRIEF.md
# Tweakable 512-bit ARX Block Cipher Core

This core encrypts a single 512-bit block, handled as eight 64-bit words, under a 512-bit key and a 128-bit tweak. It uses 72 add-rotate-xor rounds and fixed word shuffles, with key material mixed in every fourth round. A start pulse captures the key, tweak and plaintext buses. The core then runs one round per clock through an iterative datapath. It reports the ciphertext with a one-cycle done pulse.

At capture, the core derives a ninth key word and a third tweak word and holds them with the others in registers. From those twelve words it forms each injected subkey combinationally, selecting words by the subkey number. Four MIX units work side by side each cycle, and each takes its rotation amount from the row picked by the round number modulo 8. The 19th and last subkey is added in one extra cycle, which reuses the same adder path as the earlier injections. Any chaining, padding or message handling around the cipher belongs to the surrounding logic.

Top module: `tf512_core`

## Requirements
- R1: While reset is high and after it falls, done_o is low, ct_o is zero and the core is idle, so a start pulse is accepted at once.
- R2: A start pulse accepted at clock edge E gives done_o high after edge E+73: 72 round edges plus one final-injection edge.
- R3: The ninth key word equals 0x1BD11BDAA9FC1A22 XORed with all eight key words. Subkey s adds key word (s+i) mod 9 to state word i, all sums modulo 2^64.
- R4: The third tweak word is the XOR of the two tweak words. Subkey s also adds tweak word s mod 3 to state word 5 and tweak word (s+1) mod 3 to state word 6.
- R5: Pairs (0,1), (2,3), (4,5) and (6,7) each go through y0 = x0 + x1 and y1 = rotl(x1, R) XOR y0. R comes from an 8-row table indexed by round mod 8: {46,36,19,37}, {33,27,14,42}, {17,49,36,39}, {44,9,54,56}, {39,30,34,24}, {13,50,10,17}, {25,29,39,43}, {8,35,56,22}.
- R6: After the MIX stage of every round, the output words are new0=old2, new1=old1, new2=old4, new3=old7, new4=old6, new5=old5, new6=old0, new7=old3.
- R7: Subkeys 0 to 17 are added before rounds 0, 4, ..., 68. Subkey 18 is added after round 71. State word 7 also receives the subkey number s.
- R8: While the core is busy, a start pulse has no effect, and changes on the key, tweak and plaintext buses do not alter the result being computed.
- R9: done_o is high for exactly one cycle per accepted start. ct_o changes only on the edge that raises done_o and holds its value until the next result.
- R10: Word i of every 512-bit bus and of ct_o is bits [64i+63:64i]. Tweak word j is tweak_i bits [64j+63:64j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled when idle |
| key_i | input | 512 | Cipher key, eight little-endian words |
| tweak_i | input | 128 | Tweak, two words |
| pt_i | input | 512 | Plaintext block |
| done_o | output | 1 | One-cycle pulse when ct_o is updated |
| ct_o | output | 512 | Ciphertext, held until the next result |

## Verification
The internal schedule cannot be seen from the ports. The injection order, the selection of key and tweak words, the rotation rows and the shuffle therefore show up only in the final ciphertext. The bench compares that ciphertext with an arithmetic model for several patterns. These include a key alone, a tweak alone, a single low word, all ones and pseudo-random blocks, so that a wrong index in any part changes the result. The case of a start arriving mid-run is the hardest to reach. The bench raises start in the twentieth cycle and inverts every input bus at the same moment, then checks that the latency, the ciphertext and the single done pulse are unaffected.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int WORD_W     = 64;
  localparam int NWORDS     = 8;
  localparam int NKEY       = NWORDS + 1;
  localparam int NTWK       = 3;
  localparam int NROUNDS    = 72;
  localparam int INJ_PERIOD = 4;
  localparam int NSUBKEYS   = NROUNDS / INJ_PERIOD + 1;
  localparam int SIDX_W     = $clog2(NSUBKEYS);
  localparam int RND_W      = $clog2(NROUNDS + 1);
  localparam int ROT_W      = $clog2(WORD_W);
  localparam int IDX_W      = $clog2(NWORDS);
  localparam int KI_W       = $clog2(NKEY);
  localparam int TI_W       = $clog2(NTWK);
  localparam logic [WORD_W-1:0] KEY_PARITY_C = 64'h1BD11BDAA9FC1A22;

  typedef logic [NWORDS-1:0][WORD_W-1:0] blk_t;

  // rotation amounts for one round, pair p in bits [p*ROT_W +: ROT_W]
  function automatic logic [4*ROT_W-1:0] rot_row(input logic [2:0] r);
    case (r)
      3'd0:    rot_row = {6'd37, 6'd19, 6'd36, 6'd46};
      3'd1:    rot_row = {6'd42, 6'd14, 6'd27, 6'd33};
      3'd2:    rot_row = {6'd39, 6'd36, 6'd49, 6'd17};
      3'd3:    rot_row = {6'd56, 6'd54, 6'd9,  6'd44};
      3'd4:    rot_row = {6'd24, 6'd34, 6'd30, 6'd39};
      3'd5:    rot_row = {6'd17, 6'd10, 6'd50, 6'd13};
      3'd6:    rot_row = {6'd43, 6'd39, 6'd29, 6'd25};
      default: rot_row = {6'd22, 6'd56, 6'd35, 6'd8};
    endcase
  endfunction

  // source word of each destination word in the shuffle
  function automatic logic [IDX_W-1:0] perm_src(input int dst);
    case (dst)
      0:       perm_src = 3'd2;
      2:       perm_src = 3'd4;
      3:       perm_src = 3'd7;
      4:       perm_src = 3'd6;
      6:       perm_src = 3'd0;
      7:       perm_src = 3'd3;
      default: perm_src = IDX_W'(dst);
    endcase
  endfunction
endpackage

// File: rtl/tf_mix.sv
module tf_mix #(
  parameter int W    = 64,
  parameter int RW   = 6
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [RW-1:0] rot_i,
  output logic [W-1:0]  y0_o,
  output logic [W-1:0]  y1_o
);
  logic [W-1:0] sum_w;
  logic [W-1:0] rot_w;

  always_comb begin
    sum_w = a_i + b_i;
    rot_w = (b_i << rot_i) | (b_i >> (RW'(W - 1) - rot_i + 1'b1));
    y0_o  = sum_w;
    y1_o  = rot_w ^ sum_w;
  end
endmodule

// File: rtl/tf_round.sv
module tf_round
  import tf_pkg::*;
(
  input  blk_t       x_i,
  input  logic [2:0] row_i,
  output blk_t       y_o
);
  logic [4*ROT_W-1:0] rots;
  blk_t               mixed;

  assign rots = rot_row(row_i);

  for (genvar p = 0; p < NWORDS / 2; p++) begin : g_mix
    tf_mix #(.W(WORD_W), .RW(ROT_W)) u_mix (
      .a_i  (x_i[2*p]),
      .b_i  (x_i[2*p+1]),
      .rot_i(rots[p*ROT_W +: ROT_W]),
      .y0_o (mixed[2*p]),
      .y1_o (mixed[2*p+1])
    );
  end

  always_comb begin
    for (int i = 0; i < NWORDS; i++) begin
      y_o[i] = mixed[perm_src(i)];
    end
  end
endmodule

// File: rtl/tf_keysched.sv
module tf_keysched
  import tf_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load_i,
  input  blk_t                          key_i,
  input  logic [1:0][WORD_W-1:0]        tweak_i,
  input  logic [SIDX_W-1:0]             sidx_i,
  output blk_t                          sk_o
);
  logic [NKEY-1:0][WORD_W-1:0] kreg;
  logic [NTWK-1:0][WORD_W-1:0] treg;
  logic [WORD_W-1:0]           kext;

  always_comb begin
    kext = KEY_PARITY_C;
    for (int i = 0; i < NWORDS; i++) kext = kext ^ key_i[i];
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      kreg <= {kext, key_i};
      treg <= {tweak_i[0] ^ tweak_i[1], tweak_i};
    end
  end

  always_comb begin
    logic [KI_W-1:0] ki;
    logic [TI_W-1:0] t5;
    logic [TI_W-1:0] t6;
    for (int i = 0; i < NWORDS; i++) begin
      ki      = KI_W'((int'(sidx_i) + i) % NKEY);
      sk_o[i] = kreg[ki];
    end
    t5 = TI_W'(int'(sidx_i) % NTWK);
    t6 = TI_W'((int'(sidx_i) + 1) % NTWK);
    sk_o[5] = sk_o[5] + treg[t5];
    sk_o[6] = sk_o[6] + treg[t6];
    sk_o[7] = sk_o[7] + WORD_W'(sidx_i);
  end

  AST_KEY_PARITY: assert property (@(posedge clk) disable iff (rst)
    load_i |=> ((kreg[0] ^ kreg[1] ^ kreg[2] ^ kreg[3] ^ kreg[4] ^ kreg[5]
                ^ kreg[6] ^ kreg[7] ^ kreg[8]) == KEY_PARITY_C)); // R3
  AST_TWEAK_PARITY: assert property (@(posedge clk) disable iff (rst)
    load_i |=> ((treg[0] ^ treg[1] ^ treg[2]) == '0)); // R4
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(kreg) && $stable(treg))); // R8
endmodule

// File: rtl/tf512_core.sv
module tf512_core
  import tf_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start_i,
  input  logic [NWORDS*WORD_W-1:0]     key_i,
  input  logic [2*WORD_W-1:0]          tweak_i,
  input  logic [NWORDS*WORD_W-1:0]     pt_i,
  output logic                         done_o,
  output logic [NWORDS*WORD_W-1:0]     ct_o
);
  localparam logic [RND_W-1:0] RND_LAST = RND_W'(NROUNDS);

  blk_t              st;
  blk_t              sk;
  blk_t              inj;
  blk_t              rnd_y;
  logic [RND_W-1:0]  rnd;
  logic              busy;
  logic              accept;
  logic              inject;
  logic [SIDX_W-1:0] sidx;

  assign accept = start_i && !busy;
  assign inject = (int'(rnd) % INJ_PERIOD) == 0;
  assign sidx   = SIDX_W'(int'(rnd) / INJ_PERIOD);

  tf_keysched u_ks (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .key_i  (key_i),
    .tweak_i(tweak_i),
    .sidx_i (sidx),
    .sk_o   (sk)
  );

  always_comb begin
    for (int i = 0; i < NWORDS; i++) begin
      inj[i] = inject ? st[i] + sk[i] : st[i];
    end
  end

  tf_round u_round (
    .x_i  (inj),
    .row_i(rnd[2:0]),
    .y_o  (rnd_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      rnd    <= '0;
      done_o <= 1'b0;
      ct_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          busy <= 1'b1;
          rnd  <= '0;
          st   <= pt_i;
        end
      end else if (rnd == RND_LAST) begin
        ct_o   <= inj;
        done_o <= 1'b1;
        busy   <= 1'b0;
      end else begin
        st  <= rnd_y;
        rnd <= rnd + 1'b1;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_CT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(ct_o)); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> ($past(rnd) == RND_LAST && $past(busy))); // R2
  AST_BUSY_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && rnd != RND_LAST) |=> (busy && rnd == $past(rnd) + 1'b1)); // R8
endmodule

// File: tb/tf512_core_tb.sv
module tf512_core_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [511:0] key = '0;
  logic [127:0] tw = '0;
  logic [511:0] pt = '0;
  logic         done;
  logic [511:0] ct;
  int           n_chk = 0;
  int           n_fail = 0;
  logic [63:0]  seed = 64'h9E3779B97F4A7C15;

  int rot_tab [0:7][0:3] = '{'{46,36,19,37}, '{33,27,14,42}, '{17,49,36,39},
                             '{44,9,54,56}, '{39,30,34,24}, '{13,50,10,17},
                             '{25,29,39,43}, '{8,35,56,22}};
  int dst_from [0:7] = '{2,1,4,7,6,5,0,3};

  always #5 clk = ~clk;

  tf512_core dut_i (
    .clk(clk), .rst(rst), .start_i(start), .key_i(key), .tweak_i(tw),
    .pt_i(pt), .done_o(done), .ct_o(ct)
  );

  function automatic logic [511:0] model(input logic [511:0] k, input logic [127:0] t,
                                         input logic [511:0] p);
    logic [63:0] kw [0:8];
    logic [63:0] tv [0:2];
    logic [63:0] v  [0:7];
    logic [63:0] m  [0:7];
    logic [511:0] r;
    kw[8] = 64'h1BD11BDAA9FC1A22;
    for (int i = 0; i < 8; i++) begin
      kw[i] = k[64*i +: 64];
      kw[8] = kw[8] ^ kw[i];
      v[i]  = p[64*i +: 64];
    end
    tv[0] = t[63:0]; tv[1] = t[127:64]; tv[2] = tv[0] ^ tv[1];
    for (int d = 0; d <= 72; d++) begin
      if (d % 4 == 0) begin
        for (int i = 0; i < 8; i++) v[i] = v[i] + kw[(d/4 + i) % 9];
        v[5] = v[5] + tv[(d/4) % 3];
        v[6] = v[6] + tv[(d/4 + 1) % 3];
        v[7] = v[7] + 64'(d/4);
      end
      if (d < 72) begin
        for (int q = 0; q < 4; q++) begin
          m[2*q]   = v[2*q] + v[2*q+1];
          m[2*q+1] = ((v[2*q+1] << rot_tab[d%8][q]) | (v[2*q+1] >> (64 - rot_tab[d%8][q])))
                     ^ m[2*q];
        end
        for (int i = 0; i < 8; i++) v[i] = m[dst_from[i]];
      end
    end
    for (int i = 0; i < 8; i++) r[64*i +: 64] = v[i];
    return r;
  endfunction

  function automatic logic [63:0] nxt(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [511:0] k, input logic [127:0] t, input logic [511:0] p,
                     input bit poke, input string req);
    logic [511:0] exp;
    logic [511:0] got;
    int lat;
    exp = model(k, t, p);
    @(negedge clk);
    key = k; tw = t; pt = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 20) begin
        start = 1'b1; key = ~k; tw = ~t; pt = ~p;
      end else begin
        start = 1'b0;
      end
    end
    got = ct;
    // R2: start edge plus 72 rounds plus the final injection, seen one negedge later
    chk(lat == 74, {req, " R2 latency"}, 512'(lat), 512'd74);
    chk(got == exp, req, got, exp);
    @(negedge clk);
    chk(done == 1'b0, "R9 done width", 512'(done), 512'd0);
    repeat (5) @(negedge clk);
    chk(ct == got && !done, "R9 R8 hold", ct, got);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [511:0] rk;
    logic [511:0] rp;
    logic [127:0] rt;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && ct == '0, "R1 in reset", ct, '0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && ct == '0, "R1 after reset", ct, '0);

    run('0, '0, '0, 1'b0, "R7 all zero");
    run({8{64'h0123456789ABCDEF}}, '0, '0, 1'b0, "R3 key only");
    run('0, {64'hFEDCBA9876543210, 64'h0F1E2D3C4B5A6978}, '0, 1'b0, "R4 tweak only");
    run('0, '0, 512'h1, 1'b0, "R10 low word");
    run('0, '0, {64'h8000000000000000, 448'h0}, 1'b0, "R10 high word");
    run('1, '1, '1, 1'b0, "R5 all ones");
    for (int n = 0; n < 4; n++) begin
      for (int w = 0; w < 8; w++) begin
        seed = nxt(seed); rk[64*w +: 64] = seed;
        seed = nxt(seed); rp[64*w +: 64] = seed;
      end
      seed = nxt(seed); rt[63:0] = seed;
      seed = nxt(seed); rt[127:64] = seed;
      run(rk, rt, rp, 1'b0, "R6 random");
    end
    run(rk ^ {8{64'h5A5A}}, rt, rp, 1'b1, "R8 start while busy");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule